// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers single-cycle interrupt pulses from forty sources, organised as five byte-wide groups. It turns them into pending request flags and offers one winning request, with its index, to the processor. A pulse is held until the next machine-cycle strobe, and only then may it set its flag. A per-source capture mask can stop that capture altogether. Pending flags then pass through a per-source enable and a global enable that comes from the processor status word.

A control bit switches between two arbitration modes. With priority off, the lowest-numbered eligible source wins. With priority on, each source has a two-bit level, and only levels strictly above the one currently being serviced may interrupt. A small in-service record is updated on each acknowledge and on each return-from-interrupt. Software reaches every mask, flag, level and control register through a byte-wide read/write port. Four reset events all return the block to its reset state: the external reset, a break, a watchdog overflow and an illegal-opcode trap.

Top module: `irqc_top`

## Requirements
- R1: A pulse on source i sets request flag i at the next strobe only when capture-mask bit i is 0. When the bit is 1, the flag stays 0. Register byte g of each group holds sources 8g..8g+7, with bit k being source 8g+k. The capture mask is at address 0x00+g.
- R2: A pulse raised while `mstrobe_i` is low is held, and it reaches the request flags (address 0x08+g) only on the clock edge where `mstrobe_i` is high.
- R3: When `ack_i` is high while `irq_o` is high, the flag of the source on `vec_o` is cleared at that edge, and `irq_o` is low in the following cycle.
- R4: A software write to a request byte sets or clears each flag of that byte. A flag written to 1 is treated as a pending request.
- R5: A source whose enable bit (address 0x10+g) is 0 never appears on `irq_o`/`vec_o`.
- R6: While `glob_en_i` is 0, `irq_o` stays 0. Once it returns to 1, pending enabled requests are presented again.
- R7: With control bit 6 (address 0x28) at 0, the lowest-indexed eligible source wins, whatever its level.
- R8: With control bit 6 at 1, the level of source i is {bit i of the high level group (0x20+g), bit i of the low level group (0x18+g)}. The highest level wins, and a tie goes to the lowest index.
- R9: In priority mode, a source is granted only if its level is strictly above every level in service. An acknowledge marks the granted level as in service. A `reti_i` pulse releases the highest in-service level.
- R10: On any of the four reset inputs, the capture-mask, request and enable bytes 0..3 become 0x00 and byte 4 of each becomes 0xC0. The level bytes and the control register become 0x00.
- R11: If a strobe captures a flag in the same cycle that software writes that flag to 0, the flag ends at 1.
- R12: `irq_o` and `vec_o` are registered. A flag set at edge t is first presented after edge t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| brk_rst_i | input | 1 | Reset event from a break instruction, active high |
| wdog_rst_i | input | 1 | Reset event from watchdog overflow, active high |
| trap_rst_i | input | 1 | Reset event from illegal-opcode trap, active high |
| src_pulse_i | input | 40 | Interrupt pulses, one per source |
| mstrobe_i | input | 1 | Machine-cycle strobe that gates flag capture |
| glob_en_i | input | 1 | Global maskable-interrupt enable from the status word |
| ack_i | input | 1 | Single-cycle acknowledge of the presented request |
| reti_i | input | 1 | Single-cycle return-from-interrupt strobe |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register byte address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 6 | Index of the presented source |

## Verification
The assertions assume that `ack_i` and `reti_i` are single-cycle pulses. They also assume that a return-from-interrupt is never issued without a matching earlier acknowledge, and that the four reset inputs are synchronous to the clock. The stimulus drives every input on the falling edge. It raises acknowledge only in cycles where `irq_o` is high, and it issues returns only to unwind acknowledges it has made, so the in-service record never underflows. The level sweep sets up two pending sources with an empty in-service record each time, so every one of the sixteen level pairs starts from the same state.

// File: rtl/irqc_pkg.sv
// Shared constants for the interrupt controller: register group codes
// taken from the upper address bits, level count and mode bit position.
package irqc_pkg;
    localparam int          BYTE_W        = 8;
    localparam int          LEVELS        = 4;
    localparam int          LVL_W         = 2;
    localparam int          ADDR_W        = 6;
    localparam int          PRIO_MODE_BIT = 6;
    localparam logic [2:0]  GRP_MASK      = 3'd0;
    localparam logic [2:0]  GRP_REQ       = 3'd1;
    localparam logic [2:0]  GRP_EN        = 3'd2;
    localparam logic [2:0]  GRP_LVL_LO    = 3'd3;
    localparam logic [2:0]  GRP_LVL_HI    = 3'd4;
    localparam logic [2:0]  GRP_CTRL      = 3'd5;
endpackage

// File: rtl/irqc_regs.sv
// Register file and request flags. Holds the capture mask, the enables,
// the two level-bit groups and the mode bit. Pulses are held until a
// machine-cycle strobe, then captured into flags unless masked.
// Flag priority per bit: hardware capture > software write > acknowledge clear.
// Assumes NBYTES <= 8, since the low three address bits select the byte.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter  int NBYTES = 5,
    localparam int NSRC   = NBYTES * BYTE_W,
    localparam int VW     = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_evt_i,
    input  logic [NSRC-1:0]   pulse_i,
    input  logic              strobe_i,
    input  logic              ack_clr_i,
    input  logic [VW-1:0]     ack_idx_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic [NSRC-1:0]   flags_o,
    output logic [NSRC-1:0]   en_o,
    output logic [NSRC-1:0]   lvl_lo_o,
    output logic [NSRC-1:0]   lvl_hi_o,
    output logic              prio_mode_o
);
    localparam logic [NSRC-1:0] TOP_INIT = {8'hC0, {(NSRC-8){1'b0}}};

    logic [NSRC-1:0] cap_mask;
    logic [NSRC-1:0] hold;
    logic [NSRC-1:0] hw_set;
    logic [NSRC-1:0] flag_nxt;
    logic [2:0]      grp;
    int              bidx;
    logic            byte_ok;
    logic            wr_req;

    assign grp     = addr_i[5:3];
    assign bidx    = int'(addr_i[2:0]);
    assign byte_ok = (bidx < NBYTES);
    assign wr_req  = we_i && (grp == GRP_REQ) && byte_ok;
    assign hw_set  = strobe_i ? ((hold | pulse_i) & ~cap_mask) : '0;

    // Configuration registers: reset values, then byte writes from software.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt_i) begin
            cap_mask    <= TOP_INIT;
            en_o        <= TOP_INIT;
            lvl_lo_o    <= '0;
            lvl_hi_o    <= '0;
            prio_mode_o <= 1'b0;
        end else if (we_i) begin
            if (grp == GRP_CTRL && bidx == 0) begin
                prio_mode_o <= wdata_i[PRIO_MODE_BIT];
            end else if (byte_ok) begin
                case (grp)
                    GRP_MASK:   cap_mask[bidx*8 +: 8] <= wdata_i;
                    GRP_EN:     en_o[bidx*8 +: 8]     <= wdata_i;
                    GRP_LVL_LO: lvl_lo_o[bidx*8 +: 8] <= wdata_i;
                    GRP_LVL_HI: lvl_hi_o[bidx*8 +: 8] <= wdata_i;
                    default: ;
                endcase
            end
        end
    end

    // Pulse holding: accumulate pulses between strobes, empty on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt_i) hold <= '0;
        else if (strobe_i)       hold <= '0;
        else                     hold <= hold | pulse_i;
    end

    // Next flag value: acknowledge clear, then software write, then capture.
    always_comb begin
        flag_nxt = flags_o;
        if (ack_clr_i && (int'(ack_idx_i) < NSRC)) flag_nxt[ack_idx_i] = 1'b0;
        if (wr_req) flag_nxt[bidx*8 +: 8] = wdata_i;
        flag_nxt = flag_nxt | hw_set;
    end

    // Request flag register.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt_i) flags_o <= TOP_INIT;
        else                     flags_o <= flag_nxt;
    end

    // Read multiplexer, selected by group and byte.
    always_comb begin
        rdata_o = 8'h00;
        if (grp == GRP_CTRL) begin
            if (bidx == 0) rdata_o[PRIO_MODE_BIT] = prio_mode_o;
        end else if (byte_ok) begin
            case (grp)
                GRP_MASK:   rdata_o = cap_mask[bidx*8 +: 8];
                GRP_REQ:    rdata_o = flags_o[bidx*8 +: 8];
                GRP_EN:     rdata_o = en_o[bidx*8 +: 8];
                GRP_LVL_LO: rdata_o = lvl_lo_o[bidx*8 +: 8];
                GRP_LVL_HI: rdata_o = lvl_hi_o[bidx*8 +: 8];
                default:    rdata_o = 8'h00;
            endcase
        end
    end

    // R1: a masked source never gains a flag except by a software write.
    p_mask_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n || rst_evt_i)
        !wr_req |=> ((flags_o & ~$past(flags_o) & $past(cap_mask)) == '0));

    // R2: without a strobe or a software write, no flag rises.
    p_strobe_gates_r2: assert property (@(posedge clk) disable iff (!rst_n || rst_evt_i)
        (!strobe_i && !wr_req) |=> ((flags_o & ~$past(flags_o)) == '0));

    // R3: the acknowledged flag is cleared when nothing sets it again.
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n || rst_evt_i)
        (ack_clr_i && !wr_req && !hw_set[ack_idx_i]) |=> !flags_o[$past(ack_idx_i)]);

    // R11: every captured bit is 1 afterwards, whatever software wrote.
    p_hw_beats_sw_r11: assert property (@(posedge clk) disable iff (!rst_n || rst_evt_i)
        (|hw_set) |=> ((flags_o & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/irqc_select.sv
// Combinational arbiter. A source is eligible when its flag, its enable and
// the global enable are set and, in priority mode, its level is above every
// in-service level. The winner is the highest effective level, ties to the
// lowest index. With priority off, every level counts as 0.
module irqc_select
    import irqc_pkg::*;
#(
    parameter  int NBYTES = 5,
    localparam int NSRC   = NBYTES * BYTE_W,
    localparam int VW     = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   flags_i,
    input  logic [NSRC-1:0]   en_i,
    input  logic [NSRC-1:0]   lvl_lo_i,
    input  logic [NSRC-1:0]   lvl_hi_i,
    input  logic              glob_en_i,
    input  logic              prio_mode_i,
    input  logic [LEVELS-1:0] inserv_i,
    output logic              sel_valid_o,
    output logic [VW-1:0]     sel_idx_o,
    output logic [LVL_W-1:0]  sel_lvl_o
);
    logic [LEVELS-1:0] above;
    logic [LVL_W-1:0]  lvl;
    logic              ok;

    // Levels that lie above all in-service levels.
    always_comb begin
        for (int l = 0; l < LEVELS; l++) above[l] = ((inserv_i >> l) == '0);
    end

    // Scan from the top index down so a lower index replaces an equal level.
    always_comb begin
        sel_valid_o = 1'b0;
        sel_idx_o   = '0;
        sel_lvl_o   = '0;
        lvl         = '0;
        ok          = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            lvl = prio_mode_i ? {lvl_hi_i[i], lvl_lo_i[i]} : '0;
            ok  = flags_i[i] && en_i[i] && glob_en_i && (!prio_mode_i || above[lvl]);
            if (ok && (!sel_valid_o || lvl >= sel_lvl_o)) begin
                sel_valid_o = 1'b1;
                sel_idx_o   = VW'(i);
                sel_lvl_o   = lvl;
            end
        end
    end

    // R5: the chosen source is pending and individually enabled.
    p_pick_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> (flags_i[sel_idx_o] && en_i[sel_idx_o]));

    // R9: in priority mode, the winner lies above everything in service.
    p_above_inserv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_o && prio_mode_i) |-> ((inserv_i >> sel_lvl_o) == '0));
endmodule

// File: rtl/irqc_lvl_stack.sv
// In-service level record. One bit per level; the highest set bit is the
// level being serviced. A pop releases that bit and a push marks a new
// level. A pop and a push in the same cycle take effect in that order.
// Assumes a pop is never issued without an earlier push.
module irqc_lvl_stack
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_evt_i,
    input  logic              push_i,
    input  logic [LVL_W-1:0]  push_lvl_i,
    input  logic              pop_i,
    output logic [LEVELS-1:0] inserv_o
);
    logic [LEVELS-1:0] nxt;
    logic [LVL_W-1:0]  top;

    // Find the top level, release it on a pop, then apply a push.
    always_comb begin
        top = '0;
        for (int l = 0; l < LEVELS; l++) if (inserv_o[l]) top = LVL_W'(l);
        nxt = inserv_o;
        if (pop_i && (inserv_o != '0)) nxt[top] = 1'b0;
        if (push_i) nxt[push_lvl_i] = 1'b1;
    end

    // In-service register.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt_i) inserv_o <= '0;
        else                     inserv_o <= nxt;
    end

    // R9: a lone pop releases exactly one level.
    p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n || rst_evt_i)
        (pop_i && !push_i && inserv_o != '0) |=>
        ($countones(inserv_o) == $countones($past(inserv_o)) - 1));
endmodule

// File: rtl/irqc_top.sv
// Prioritized maskable interrupt controller top. Joins the register file,
// the arbiter and the in-service record, and registers the request line
// and vector. Any of the four reset inputs restores the reset state.
// Assumes ack_i and reti_i are single-cycle pulses.
module irqc_top
    import irqc_pkg::*;
#(
    parameter  int NBYTES = 5,
    localparam int NSRC   = NBYTES * BYTE_W,
    localparam int VW     = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              brk_rst_i,
    input  logic              wdog_rst_i,
    input  logic              trap_rst_i,
    input  logic [NSRC-1:0]   src_pulse_i,
    input  logic              mstrobe_i,
    input  logic              glob_en_i,
    input  logic              ack_i,
    input  logic              reti_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              irq_o,
    output logic [VW-1:0]     vec_o
);
    logic              rst_evt;
    logic              ack_take;
    logic [NSRC-1:0]   flags, en, lvl_lo, lvl_hi;
    logic              prio_mode;
    logic [LEVELS-1:0] inserv;
    logic              sel_valid;
    logic [VW-1:0]     sel_idx;
    logic [LVL_W-1:0]  sel_lvl;

    assign rst_evt  = brk_rst_i | wdog_rst_i | trap_rst_i;
    assign ack_take = ack_i && irq_o;

    irqc_regs #(.NBYTES(NBYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .rst_evt_i(rst_evt),
        .pulse_i(src_pulse_i), .strobe_i(mstrobe_i),
        .ack_clr_i(ack_take), .ack_idx_i(vec_o),
        .we_i(bus_we_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
        .rdata_o(bus_rdata_o), .flags_o(flags), .en_o(en),
        .lvl_lo_o(lvl_lo), .lvl_hi_o(lvl_hi), .prio_mode_o(prio_mode)
    );

    irqc_select #(.NBYTES(NBYTES)) u_sel (
        .clk(clk), .rst_n(rst_n),
        .flags_i(flags), .en_i(en), .lvl_lo_i(lvl_lo), .lvl_hi_i(lvl_hi),
        .glob_en_i(glob_en_i), .prio_mode_i(prio_mode), .inserv_i(inserv),
        .sel_valid_o(sel_valid), .sel_idx_o(sel_idx), .sel_lvl_o(sel_lvl)
    );

    irqc_lvl_stack u_stack (
        .clk(clk), .rst_n(rst_n), .rst_evt_i(rst_evt),
        .push_i(ack_take && prio_mode),
        .push_lvl_i({lvl_hi[vec_o], lvl_lo[vec_o]}),
        .pop_i(reti_i), .inserv_o(inserv)
    );

    // Registered processor outputs; the request drops in the cycle after an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt) begin
            irq_o <= 1'b0;
            vec_o <= '0;
        end else begin
            irq_o <= sel_valid && !ack_take;
            vec_o <= sel_idx;
        end
    end

    // R6: a request is presented only if the global enable was high.
    p_irq_needs_global_r6: assert property (@(posedge clk) disable iff (!rst_n || rst_evt)
        irq_o |-> $past(glob_en_i));

    // R3: an accepted request is withdrawn in the next cycle.
    p_ack_drops_r3: assert property (@(posedge clk) disable iff (!rst_n || rst_evt)
        ack_take |=> !irq_o);
endmodule

// File: tb/sim_irqc_top.sv
// Bench for irqc_top: sweeps every source through capture, presentation and
// acknowledge, plus mask patterns, enables, modes, all level pairs of two
// sources, nesting and the reset events.
module sim_irqc_top;
    localparam int NB = 5;
    localparam int NS = NB * 8;
    localparam logic [5:0] A_MASK = 6'd0, A_REQ = 6'd8, A_EN = 6'd16,
                           A_LO = 6'd24, A_HI = 6'd32, A_CTRL = 6'd40;

    logic clk = 1'b0, rst_n = 1'b0, brk = 1'b0, wdog = 1'b0, trap = 1'b0;
    logic [NS-1:0] src = '0;
    logic mstrobe = 1'b0, glob_en = 1'b0, ack = 1'b0, reti = 1'b0, we = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic irq;
    logic [5:0] vec;
    int n_run = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    irqc_top #(.NBYTES(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .brk_rst_i(brk), .wdog_rst_i(wdog), .trap_rst_i(trap),
        .src_pulse_i(src), .mstrobe_i(mstrobe), .glob_en_i(glob_en), .ack_i(ack),
        .reti_i(reti), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .vec_o(vec)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic tick(); @(posedge clk); @(negedge clk); endtask

    task automatic chk(string r, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        we = 1'b1; addr = a; wdata = d; tick(); we = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [7:0] d);
        addr = a; #1 d = rdata;
    endtask

    task automatic wr_all(logic [5:0] base, logic [7:0] d);
        for (int b = 0; b < NB; b++) wr(base + 6'(b), d);
    endtask

    task automatic do_ack(); ack = 1'b1; tick(); ack = 1'b0; endtask
    task automatic do_reti(); reti = 1'b1; tick(); reti = 1'b0; endtask

    initial begin
        logic [7:0] d;
        @(negedge clk); tick(); tick(); rst_n = 1'b1;

        // R10: reset state of every group.
        for (int b = 0; b < NB; b++) begin
            int e;
            e = (b == NB - 1) ? 8'hC0 : 8'h00;
            rd(A_MASK + 6'(b), d); chk("R10 mask reset", d, e);
            rd(A_REQ + 6'(b), d);  chk("R10 req reset", d, e);
            rd(A_EN + 6'(b), d);   chk("R10 en reset", d, e);
        end
        chk("R6 no irq with global enable low", irq, 0);

        // Setup: clear the top byte, enable all sources, priority off.
        wr(A_REQ + 6'd4, 8'h00); wr(A_MASK + 6'd4, 8'h00);
        wr_all(A_EN, 8'hFF); glob_en = 1'b1; tick();

        // Sweep every source: hold, capture, register, acknowledge.
        for (int i = 0; i < NS; i++) begin
            logic [5:0] ra;
            ra = A_REQ + 6'(i / 8);
            src[i] = 1'b1; tick(); src = '0; tick();
            rd(ra, d); chk("R2 held until strobe", d, 0);
            mstrobe = 1'b1; tick(); mstrobe = 1'b0;
            rd(ra, d); chk("R1 unmasked pulse sets flag", d, 1 << (i % 8));
            chk("R12 irq one cycle later", irq, 0);
            tick();
            chk("R12 irq presented", irq, 1); chk("R7 vector", vec, i);
            do_ack();
            rd(ra, d); chk("R3 flag cleared", d, 0); chk("R3 irq dropped", irq, 0);
            tick(); chk("R3 no further irq", irq, 0);
        end

        // R1: masked pattern across all bytes.
        wr_all(A_MASK, 8'hA5); glob_en = 1'b0;
        src = '1; tick(); src = '0; mstrobe = 1'b1; tick(); mstrobe = 1'b0;
        for (int b = 0; b < NB; b++) begin
            rd(A_REQ + 6'(b), d); chk("R1 masked pattern", d, 8'h5A);
        end
        tick(); tick(); chk("R6 blocked by global enable", irq, 0);
        glob_en = 1'b1; tick();
        chk("R6 irq after global enable", irq, 1); chk("R6 vector", vec, 1);
        wr_all(A_REQ, 8'h00); wr_all(A_MASK, 8'h00); tick();
        chk("R4 software clear removes requests", irq, 0);

        // R5/R4: enable gating with software-set flags.
        wr_all(A_EN, 8'h00); wr(A_EN, 8'h0C); wr(A_REQ, 8'h0F); tick();
        chk("R4 software set pending", irq, 1); chk("R5 first enabled source", vec, 2);
        wr(A_EN, 8'h00); tick(); chk("R5 disabled source blocked", irq, 0);
        wr(A_REQ, 8'h00); wr_all(A_EN, 8'hFF);

        // R7/R8: levels. Source 3 at level 0, 9 and 20 at level 3, 5 at level 2, 6 at level 1.
        wr(A_LO, 8'h40); wr(A_HI, 8'h20);
        wr(A_LO + 6'd1, 8'h02); wr(A_HI + 6'd1, 8'h02);
        wr(A_LO + 6'd2, 8'h10); wr(A_HI + 6'd2, 8'h10);
        wr(A_REQ, 8'h08); wr(A_REQ + 6'd1, 8'h02); wr(A_REQ + 6'd2, 8'h10); tick();
        chk("R7 lowest index without priority", vec, 3);
        wr(A_CTRL, 8'h40); rd(A_CTRL, d); chk("R7 mode bit reads back", d, 8'h40);
        tick(); chk("R8 highest level, lowest index", vec, 9);

        // R9: nesting.
        do_ack(); tick(); chk("R9 equal level not granted", irq, 0);
        do_reti(); tick(); chk("R9 after return", irq, 1); chk("R9 next level 3", vec, 20);
        do_ack(); do_reti(); tick(); chk("R9 level 0 after unwinding", vec, 3);
        do_ack(); wr(A_REQ, 8'h20); tick(); chk("R9 level 2 nests over 0", vec, 5);
        do_ack(); wr(A_REQ, 8'h40); tick(); chk("R9 level 1 blocked under 2", irq, 0);
        do_reti(); tick(); chk("R9 level 1 above 0 after return", vec, 6);
        do_ack(); do_reti(); do_reti(); tick(); chk("R9 nothing left", irq, 0);

        // R8: every level pair for sources 1 and 30.
        wr_all(A_LO, 8'h00); wr_all(A_HI, 8'h00);
        wr(A_REQ, 8'h02); wr(A_REQ + 6'd3, 8'h40);
        for (int la = 0; la < 4; la++) begin
            for (int lb = 0; lb < 4; lb++) begin
                wr(A_LO, 8'((la & 1) << 1)); wr(A_HI, 8'((la >> 1) << 1));
                wr(A_LO + 6'd3, 8'((lb & 1) << 6)); wr(A_HI + 6'd3, 8'((lb >> 1) << 6));
                tick(); chk("R8 level pair", vec, (lb > la) ? 30 : 1);
            end
        end
        wr_all(A_REQ, 8'h00); wr(A_CTRL, 8'h00);

        // R11: capture and software clear in the same cycle.
        src[10] = 1'b1; tick(); src = '0;
        mstrobe = 1'b1; wr(A_REQ + 6'd1, 8'h00); mstrobe = 1'b0;
        rd(A_REQ + 6'd1, d); chk("R11 capture wins over clear", d, 8'h04);
        wr(A_REQ + 6'd1, 8'h00);

        // R10: each reset event.
        for (int e = 0; e < 3; e++) begin
            wr(A_REQ, 8'h33); wr(A_MASK + 6'd1, 8'h11); wr(A_CTRL, 8'h40); wr(A_LO, 8'hFF);
            brk = (e == 0); wdog = (e == 1); trap = (e == 2);
            tick(); brk = 1'b0; wdog = 1'b0; trap = 1'b0;
            rd(A_REQ, d);          chk("R10 event clears req", d, 0);
            rd(A_MASK + 6'd1, d);  chk("R10 event clears mask", d, 0);
            rd(A_REQ + 6'd4, d);   chk("R10 event top req", d, 8'hC0);
            rd(A_EN + 6'd4, d);    chk("R10 event top en", d, 8'hC0);
            rd(A_MASK + 6'd4, d);  chk("R10 event top mask", d, 8'hC0);
            rd(A_CTRL, d);         chk("R10 event ctrl", d, 0);
            rd(A_LO, d);           chk("R10 event level", d, 0);
            chk("R10 irq low after event", irq, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule